// File: doc/BRIEF.md
# Ethernet Transmit Status Tracker

This block keeps the per-frame transmit status of a 10 Mbps CSMA/CD MAC and shows it as a 16-bit status word. It watches byte-time strobes, frame boundaries, the deferral, carrier and collision signals, and the link-integrity state. It owns the transmit-enable flag. Two error conditions clear that flag: carrier missing at the end of the preamble, and a collision that arrives too late in the frame. Each status flag has its own clearing event.

When a tracked frame ends, the block emits a one-cycle completion pulse together with a snapshot of the status word. The surrounding logic writes that snapshot as the leading word of the packet's buffer. The live word then goes on to serve later frames. A late collision also raises a jam request that lasts a fixed number of byte times.

Top module: `eth_txstat_tracker`

## Requirements
- R1: While `rst` is high at a clock edge, every status bit, `tx_enable`, `jam_req`, `link_irq`, `done_pulse` and `done_status` are zero after that edge.
- R2: Status word layout: bit0 excessive deferral, bit1 lost carrier, bit2 late collision, bit3 counter rollover, bit4 link OK, bit5 transmit enable. Bits 15..6 read zero.
- R3: `txen_set` sets `tx_enable` and clears the lost-carrier and late-collision flags one clock later. `txen_clr` clears `tx_enable`. An error event in the same cycle overrides `txen_set`.
- R4: Bit4 shows `link_in` one clock later. When the registered link state differs from `link_in` while `link_evt_en` is high, `link_irq` pulses for one cycle at that same edge. When `link_evt_en` is low, no pulse is produced.
- R5: A `cnt_rollover` pulse sets bit3 and an `ecr_read` pulse clears it. If both occur in the same cycle, the bit is set.
- R6: During a tracked frame, byte ticks with `defer_active` high are counted from `frame_start` in a saturating 12-bit counter. Once the count exceeds 3036, bit0 sets on the next edge. The bit clears when the tracked frame ends.
- R7: If `preamble_end` arrives in a tracked frame with `carrier_mon_en` high and `carrier_sense` low, bit1 sets and `tx_enable` clears. With `carrier_mon_en` low, the same event has no effect.
- R8: A collision in a tracked frame after more than 64 byte ticks since `frame_start` sets bit2 and clears `tx_enable`. A collision at exactly 64 ticks or fewer has no effect.
- R9: A late collision raises `jam_req` on the next edge. `jam_req` drops on the 4th later byte tick.
- R10: When a tracked frame ends, `done_pulse` is high for exactly one cycle after that edge. `done_status` then holds the status word from the cycle in which `frame_end` was high.
- R11: A frame is tracked only if it starts while `tx_enable` is high. Frames started while it is low produce no snapshot and leave bits 0..2 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_tick | input | 1 | One-cycle strobe per byte time |
| frame_start | input | 1 | Start of a frame attempt (deferral begins) |
| frame_end | input | 1 | End of the current frame |
| defer_active | input | 1 | Transmitter is deferring |
| preamble_end | input | 1 | Strobe at end of preamble |
| carrier_sense | input | 1 | Carrier detected on the medium |
| carrier_mon_en | input | 1 | Enables the lost-carrier check |
| collision | input | 1 | Collision detected |
| link_in | input | 1 | Link-integrity test result |
| link_evt_en | input | 1 | Enables the link-change interrupt |
| cnt_rollover | input | 1 | A statistics counter reached 15 |
| ecr_read | input | 1 | Error-counter register read strobe |
| txen_set | input | 1 | Software sets transmit enable |
| txen_clr | input | 1 | Software clears transmit enable |
| status_word | output | 16 | Live status word |
| tx_enable | output | 1 | Transmit enable |
| jam_req | output | 1 | Jam request after a late collision |
| link_irq | output | 1 | One-cycle link-change interrupt |
| done_pulse | output | 1 | Frame completion pulse |
| done_status | output | 16 | Status snapshot for packet memory |

## Verification
A wrong byte counter shows up at the threshold. If the late-collision counter is off by one, bit2 and `jam_req` appear after a collision at tick 64, or fail to appear at tick 65, at the edge after the collision. A deferral counter that drifts moves the rise of bit0 by one byte tick around count 3037. A stuck or missing frame-tracking state appears at the next `frame_end` as an extra, missing or wrong snapshot. The scoreboard catches this within one cycle, and also catches a leftover entry at the end of the run.

// File: rtl/eth_txstat_pkg.sv
package eth_txstat_pkg;
  localparam int STAT_W = 16;

  // flag order (MSB first) fixes the status word bit positions 5..0
  typedef struct packed {
    logic txen;
    logic link_ok;
    logic cnt_roll;
    logic late_col;
    logic lost_car;
    logic exc_def;
  } txs_flags_t;

  localparam int FLAG_W = $bits(txs_flags_t);

  function automatic logic [STAT_W-1:0] txs_pack(input txs_flags_t f);
    return {{(STAT_W-FLAG_W){1'b0}}, f};
  endfunction
endpackage

// File: rtl/txs_defer_mon.sv
module txs_defer_mon #(
  parameter int CNT_W = 12,
  parameter int LIMIT = 3036
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             defer_active,
  input  logic             byte_tick,
  output logic             over,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] LIM_V   = CNT_W'(LIMIT);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      count <= '0;
    end else if (defer_active && byte_tick && count != CNT_MAX) begin
      count <= count + 1'b1;
    end
  end

  assign over = (count > LIM_V);
endmodule

// File: rtl/txs_coll_mon.sv
module txs_coll_mon #(
  parameter int LATE_AFTER = 64,
  parameter int JAM_BYTES  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_start,
  input  logic byte_tick,
  input  logic collision,
  input  logic arm,
  output logic late_evt,
  output logic jam_req
);
  localparam int CNT_W = $clog2(LATE_AFTER + 2);
  localparam int JAM_W = $clog2(JAM_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] LATE_V  = CNT_W'(LATE_AFTER);
  localparam logic [JAM_W-1:0] JAM_V   = JAM_W'(JAM_BYTES);

  logic [CNT_W-1:0] bcnt;
  logic [JAM_W-1:0] jcnt;

  always_ff @(posedge clk) begin
    if (rst || frame_start) begin
      bcnt <= '0;
    end else if (byte_tick && bcnt != CNT_MAX) begin
      bcnt <= bcnt + 1'b1;
    end
  end

  assign late_evt = arm && collision && (bcnt > LATE_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      jam_req <= 1'b0;
      jcnt    <= '0;
    end else if (late_evt) begin
      jam_req <= 1'b1;
      jcnt    <= JAM_V;
    end else if (jam_req && byte_tick) begin
      if (jcnt == JAM_W'(1)) jam_req <= 1'b0;
      jcnt <= jcnt - 1'b1;
    end
  end
endmodule

// File: rtl/txs_link_mon.sv
module txs_link_mon (
  input  logic clk,
  input  logic rst,
  input  logic link_in,
  input  logic evt_en,
  output logic link_q,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      link_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      link_q <= link_in;
      irq    <= evt_en && (link_q != link_in);
    end
  end
endmodule

// File: rtl/eth_txstat_tracker.sv
module eth_txstat_tracker
  import eth_txstat_pkg::*;
#(
  parameter int DEFER_W    = 12,
  parameter int DEFER_MAX  = 3036,
  parameter int LATE_AFTER = 64,
  parameter int JAM_BYTES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_tick,
  input  logic              frame_start,
  input  logic              frame_end,
  input  logic              defer_active,
  input  logic              preamble_end,
  input  logic              carrier_sense,
  input  logic              carrier_mon_en,
  input  logic              collision,
  input  logic              link_in,
  input  logic              link_evt_en,
  input  logic              cnt_rollover,
  input  logic              ecr_read,
  input  logic              txen_set,
  input  logic              txen_clr,
  output logic [STAT_W-1:0] status_word,
  output logic              tx_enable,
  output logic              jam_req,
  output logic              link_irq,
  output logic              done_pulse,
  output logic [STAT_W-1:0] done_status
);
  logic               frame_active;
  logic               exc_def, lost_car, late_col, cnt_roll, link_q;
  logic               defer_over, late_evt, lost_evt;
  logic [DEFER_W-1:0] defer_cnt;
  txs_flags_t         flags;

  txs_defer_mon #(.CNT_W(DEFER_W), .LIMIT(DEFER_MAX)) u_defer (
    .clk(clk), .rst(rst), .restart(frame_start), .defer_active(defer_active),
    .byte_tick(byte_tick), .over(defer_over), .count(defer_cnt)
  );

  txs_coll_mon #(.LATE_AFTER(LATE_AFTER), .JAM_BYTES(JAM_BYTES)) u_coll (
    .clk(clk), .rst(rst), .frame_start(frame_start), .byte_tick(byte_tick),
    .collision(collision), .arm(frame_active && tx_enable),
    .late_evt(late_evt), .jam_req(jam_req)
  );

  txs_link_mon u_link (
    .clk(clk), .rst(rst), .link_in(link_in), .evt_en(link_evt_en),
    .link_q(link_q), .irq(link_irq)
  );

  assign lost_evt = preamble_end && carrier_mon_en && !carrier_sense &&
                    frame_active && tx_enable;

  always_comb begin
    flags.txen     = tx_enable;
    flags.link_ok  = link_q;
    flags.cnt_roll = cnt_roll;
    flags.late_col = late_col;
    flags.lost_car = lost_car;
    flags.exc_def  = exc_def;
  end

  assign status_word = txs_pack(flags);

  // transmit enable and the flags it clears; error events win over software set
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_enable <= 1'b0;
      lost_car  <= 1'b0;
      late_col  <= 1'b0;
    end else begin
      if (txen_clr) tx_enable <= 1'b0;
      if (txen_set) begin
        tx_enable <= 1'b1;
        lost_car  <= 1'b0;
        late_col  <= 1'b0;
      end
      if (lost_evt) begin
        lost_car  <= 1'b1;
        tx_enable <= 1'b0;
      end
      if (late_evt) begin
        late_col  <= 1'b1;
        tx_enable <= 1'b0;
      end
    end
  end

  // rollover: a new event beats a simultaneous read
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_roll <= 1'b0;
    end else begin
      if (ecr_read)     cnt_roll <= 1'b0;
      if (cnt_rollover) cnt_roll <= 1'b1;
    end
  end

  // frame tracking, deferral flag and completion snapshot
  always_ff @(posedge clk) begin
    if (rst) begin
      frame_active <= 1'b0;
      exc_def      <= 1'b0;
      done_pulse   <= 1'b0;
      done_status  <= '0;
    end else begin
      done_pulse <= 1'b0;
      if (frame_active && defer_over) exc_def <= 1'b1;
      if (frame_end && frame_active) begin
        frame_active <= 1'b0;
        exc_def      <= 1'b0;
        done_pulse   <= 1'b1;
        done_status  <= status_word;
      end else if (frame_start && tx_enable) begin
        frame_active <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/txs_checker.sv
module txs_checker #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic [15:0]      status_word,
  input logic             tx_enable,
  input logic             jam_req,
  input logic             link_irq,
  input logic             link_evt_en,
  input logic             done_pulse,
  input logic             ecr_read,
  input logic             frame_start,
  input logic [CNT_W-1:0] defer_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assert_lost_drops_txen_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(status_word[1]) |-> !tx_enable);

  assert_late_jams_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(status_word[2]) |-> (jam_req && !tx_enable));

  assert_irq_enabled_R4: assert property (@(posedge clk) disable iff (rst)
    link_irq |-> $past(link_evt_en));

  assert_irq_on_change_R4: assert property (@(posedge clk) disable iff (rst)
    link_irq |-> (status_word[4] != $past(status_word[4])));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done_pulse |=> !done_pulse);

  assert_exc_cleared_R6: assert property (@(posedge clk) disable iff (rst)
    done_pulse |-> !status_word[0]);

  assert_defer_saturates_R6: assert property (@(posedge clk) disable iff (rst)
    (defer_cnt == CNT_MAX && !frame_start) |=> defer_cnt == CNT_MAX);

  assert_roll_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (status_word[3] && !ecr_read) |=> status_word[3]);
endmodule

bind eth_txstat_tracker txs_checker #(.CNT_W(DEFER_W)) u_chk (
  .clk(clk), .rst(rst), .status_word(status_word), .tx_enable(tx_enable),
  .jam_req(jam_req), .link_irq(link_irq), .link_evt_en(link_evt_en),
  .done_pulse(done_pulse), .ecr_read(ecr_read), .frame_start(frame_start),
  .defer_cnt(defer_cnt)
);

// File: tb/eth_txstat_tracker_tb.sv
module eth_txstat_tracker_tb;
  logic clk = 0;
  logic rst = 1;
  logic byte_tick = 0, frame_start = 0, frame_end = 0, defer_active = 0;
  logic preamble_end = 0, carrier_sense = 0, carrier_mon_en = 0, collision = 0;
  logic link_in = 0, link_evt_en = 0, cnt_rollover = 0, ecr_read = 0;
  logic txen_set = 0, txen_clr = 0;
  logic [15:0] status_word, done_status;
  logic tx_enable, jam_req, link_irq, done_pulse;

  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_q[$];
  logic m_exc = 0, m_lost = 0, m_late = 0, m_roll = 0, m_link = 0, m_txen = 0;

  always #5 clk = ~clk;

  eth_txstat_tracker u_dut (.*);

  function automatic logic [15:0] exp_word();
    return {10'b0, m_txen, m_link, m_roll, m_late, m_lost, m_exc};
  endfunction

  task automatic step(); @(negedge clk); endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_word(input string req);
    chk(req, status_word, exp_word());
  endtask

  // monitor: compares every completion snapshot against the queue
  always @(posedge clk) begin
    #1;
    if (!rst && done_pulse) begin
      if (exp_q.size() == 0) begin
        chk("R11 unexpected snapshot", done_status, 16'hxxxx);
      end else begin
        chk("R10 snapshot", done_status, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    step(); step();
    chk("R1 status", status_word, 16'h0000);
    chk("R1 outputs", {12'b0, tx_enable, jam_req, link_irq, done_pulse}, 16'h0);
    chk("R1 snapshot", done_status, 16'h0000);
    rst = 0;

    // R4 link follow and interrupt
    link_evt_en = 1; link_in = 1; step(); m_link = 1;
    chk("R4 irq on rise", {15'b0, link_irq}, 16'h1);
    chk_word("R4 link bit / R2 layout");
    step();
    chk("R4 irq one cycle", {15'b0, link_irq}, 16'h0);
    link_evt_en = 0; link_in = 0; step(); m_link = 0;
    chk("R4 irq masked", {15'b0, link_irq}, 16'h0);
    chk_word("R4 link low");
    link_in = 1; step(); m_link = 1; link_evt_en = 1; step();
    chk("R4 no irq without change", {15'b0, link_irq}, 16'h0);

    // R3 set enable
    txen_set = 1; step(); txen_set = 0; m_txen = 1;
    chk_word("R3 enable set");

    // R10 clean frame, carrier present (R7)
    carrier_mon_en = 1; carrier_sense = 1;
    frame_start = 1; step(); frame_start = 0;
    preamble_end = 1; step(); preamble_end = 0;
    chk_word("R7 carrier present");
    frame_end = 1; exp_q.push_back(exp_word()); step(); frame_end = 0;
    step();

    // R7 lost carrier
    frame_start = 1; step(); frame_start = 0;
    carrier_sense = 0; preamble_end = 1; step(); preamble_end = 0;
    m_lost = 1; m_txen = 0;
    chk_word("R7 lost carrier");
    frame_end = 1; exp_q.push_back(exp_word()); step(); frame_end = 0;
    txen_set = 1; step(); txen_set = 0; m_lost = 0; m_txen = 1;
    chk_word("R3 set clears lost carrier");

    // R7 monitor disabled
    carrier_mon_en = 0;
    frame_start = 1; step(); frame_start = 0;
    preamble_end = 1; step(); preamble_end = 0;
    chk_word("R7 monitor off ignored");
    frame_end = 1; exp_q.push_back(exp_word()); step(); frame_end = 0;
    carrier_mon_en = 1; carrier_sense = 1;

    // R8 late collision threshold, R9 jam
    frame_start = 1; step(); frame_start = 0;
    byte_tick = 1; repeat (64) step(); byte_tick = 0;
    collision = 1; step(); collision = 0;
    chk_word("R8 collision at 64 ignored");
    chk("R9 no jam at 64", {15'b0, jam_req}, 16'h0);
    byte_tick = 1; step(); byte_tick = 0;
    collision = 1; step(); collision = 0;
    m_late = 1; m_txen = 0;
    chk_word("R8 late collision at 65");
    chk("R9 jam raised", {15'b0, jam_req}, 16'h1);
    byte_tick = 1; repeat (3) step();
    chk("R9 jam held", {15'b0, jam_req}, 16'h1);
    step(); byte_tick = 0;
    chk("R9 jam dropped", {15'b0, jam_req}, 16'h0);
    frame_end = 1; exp_q.push_back(exp_word()); step(); frame_end = 0;

    // R11 disabled frames are not tracked
    frame_start = 1; step(); frame_start = 0;
    carrier_sense = 0; preamble_end = 1; defer_active = 1; byte_tick = 1;
    repeat (80) step();
    collision = 1; preamble_end = 0; step(); collision = 0;
    byte_tick = 0; defer_active = 0; carrier_sense = 1;
    frame_end = 1; step(); frame_end = 0; step(); step();
    chk_word("R11 status held while disabled");

    // R3 software clear
    txen_set = 1; step(); txen_set = 0; m_late = 0; m_txen = 1;
    chk_word("R3 set clears late collision");
    txen_clr = 1; step(); txen_clr = 0; m_txen = 0;
    chk_word("R3 enable cleared");
    txen_set = 1; step(); txen_set = 0; m_txen = 1;

    // R6 excessive deferral
    frame_start = 1; step(); frame_start = 0;
    defer_active = 1; byte_tick = 1; repeat (3036) step(); byte_tick = 0;
    step();
    chk_word("R6 not set at 3036");
    byte_tick = 1; step(); byte_tick = 0; step(); m_exc = 1;
    chk_word("R6 set past 3036");
    byte_tick = 1; repeat (1100) step(); byte_tick = 0; step();
    chk_word("R6 flag holds through saturation");
    defer_active = 0;
    frame_end = 1; exp_q.push_back(exp_word()); step(); frame_end = 0; m_exc = 0;
    chk_word("R6 cleared at frame end");

    // R5 rollover
    cnt_rollover = 1; step(); cnt_rollover = 0; m_roll = 1;
    chk_word("R5 rollover set");
    ecr_read = 1; step(); ecr_read = 0; m_roll = 0;
    chk_word("R5 read clears");
    cnt_rollover = 1; ecr_read = 1; step(); cnt_rollover = 0; ecr_read = 0; m_roll = 1;
    chk_word("R5 set wins over read");
    step();
    chk_word("R5 holds");
    ecr_read = 1; step(); ecr_read = 0; m_roll = 0;
    chk_word("R5 cleared again");

    step(); step();
    chk("R10 all snapshots seen", 16'(exp_q.size()), 16'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule